// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Peripheral Override

This block controls a byte-wide group of general-purpose pins from a small register bus. Software holds two stored registers: a data latch and a direction register. A third, read-only address returns the logic levels sampled on the pins. For each pin the block produces an output enable, an output value and a pull-up enable, which the pad ring uses directly.

The data latch bit does two jobs. On an output pin it is the value driven onto the pad. On an input pin it switches the weak pull-up on.

Two override inputs let a serial peripheral take over pins without touching the stored registers:
- A receive enable makes the receive pin an input. The pull-up on that pin still follows its latch bit.
- A transmit enable makes the transmit pin an output, driven from the peripheral's serial data.

Incoming pin levels pass through a multi-flop synchronizer before software can read them. Reset clears both registers asynchronously and forces every output enable low, even while no clock runs.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data latch and the direction register read back 0x00, and every output enable and every pull-up enable is 0.
- R2: A bus write to offset 3 loads the data latch, and a bus write to offset 2 loads the direction register. Each is visible on the next clock, and reading the same offset returns the stored byte.
- R3: A pin whose direction bit is 1 (and that is not overridden) has its output enable at 1, its output value equal to its latch bit, and its pull-up at 0.
- R4: A pin whose direction bit is 0 (and that is not overridden) has its output enable at 0, and its pull-up enable equal to its latch bit.
- R5: Reading offset 1 returns the pin levels as they were two clocks earlier, because of a two-stage synchronizer. Reading offset 3 returns the latch, never the pins.
- R6: While the receive enable is 1, bit 0 has its output enable at 0 regardless of its direction bit, and its pull-up enable equals latch bit 0.
- R7: While the transmit enable is 1, bit 1 has its output enable at 1, its output value equal to the transmit data input, and its pull-up at 0. The latch and direction registers keep their stored values.
- R8: A bus write to offset 1 changes neither the data latch nor the direction register.
- R9: Asserting the active-low reset drives every output enable to 0 at once, without waiting for a clock edge, and this holds even while the transmit override is active.
- R10: Reading any offset other than 1, 2 or 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_en | input | 1 | Receive override: bit 0 forced to input |
| tx_en | input | 1 | Transmit override: bit 1 forced to output |
| tx_data | input | 1 | Serial data driven on bit 1 under override |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
Different results are due at different points after a stimulus:
- Pad controls and the read mux are combinational, so they are due in the same cycle in which their inputs change.
- A register write is due on the cycle after its write strobe.
- A pin level is due on offset 1 two cycles after the pad changes. In the cycles before that, the old level must still show.

The driver records each expectation together with the cycle number at which it falls due. A monitor compares expectations only at the falling edge of that cycle, so every check samples exactly where the result lands. The asynchronous reset is checked within the same half cycle in which reset falls, with no edge in between.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // register selected by a bus offset
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PIN  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_DATA = 2'd3
   } gpio_sel_e;

   function automatic gpio_sel_e decode_sel(input int unsigned ofs,
                                            input int unsigned pin_ofs,
                                            input int unsigned dir_ofs,
                                            input int unsigned data_ofs);
      if (ofs == data_ofs)     return SEL_DATA;
      else if (ofs == dir_ofs) return SEL_DIR;
      else if (ofs == pin_ofs) return SEL_PIN;
      else                     return SEL_NONE;
   endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  gpio_sel_e        sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else if (wr_en) begin
         if (sel == SEL_DATA) latch_q <= wdata;
         if (sel == SEL_DIR)  dir_q   <= wdata;
      end
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int WIDTH  = 8,
   parameter bit USE_RX = 1'b1,
   parameter bit USE_TX = 1'b1,
   parameter int RX_BIT = 0,
   parameter int TX_BIT = 1
)(
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic             rx_en,
   input  logic             tx_en,
   input  logic             tx_data,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_pu
);
   logic [WIDTH-1:0] oe_raw;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (USE_RX && i == RX_BIT) begin : g_rx
         // receive override: input only, pull-up still from latch
         assign oe_raw[i]  = rx_en ? 1'b0 : dir_q[i];
         assign pin_out[i] = latch_q[i];
         assign pin_pu[i]  = rx_en ? latch_q[i] : (latch_q[i] & ~dir_q[i]);
      end else if (USE_TX && i == TX_BIT) begin : g_tx
         // transmit override: driven from serial data
         assign oe_raw[i]  = tx_en | dir_q[i];
         assign pin_out[i] = tx_en ? tx_data : latch_q[i];
         assign pin_pu[i]  = ~tx_en & latch_q[i] & ~dir_q[i];
      end else begin : g_plain
         assign oe_raw[i]  = dir_q[i];
         assign pin_out[i] = latch_q[i];
         assign pin_pu[i]  = latch_q[i] & ~dir_q[i];
      end
   end

   // reset tri-states the port without needing a clock
   assign pin_oe = rst_n ? oe_raw : '0;

   if (!USE_RX) begin : g_no_rx
      logic unused_rx;
      assign unused_rx = rx_en;
   end
   if (!USE_TX) begin : g_no_tx
      logic unused_tx;
      assign unused_tx = tx_en ^ tx_data;
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 3,
   parameter int PIN_OFS     = 1,
   parameter int DIR_OFS     = 2,
   parameter int DATA_OFS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_RX      = 1'b1,
   parameter bit USE_TX      = 1'b1,
   parameter int RX_BIT      = 0,
   parameter int TX_BIT      = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              tx_data,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_pu
);
   localparam int NUM_OFS = 1 << ADDR_W;

   // elaboration checks
   if (WIDTH < 2) begin : g_bad_width
      $error("gpio_port: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end
   if (PIN_OFS >= NUM_OFS || DIR_OFS >= NUM_OFS || DATA_OFS >= NUM_OFS) begin : g_bad_ofs
      $error("gpio_port: offset outside address range");
   end
   if (PIN_OFS == DIR_OFS || PIN_OFS == DATA_OFS || DIR_OFS == DATA_OFS) begin : g_dup_ofs
      $error("gpio_port: offsets must differ");
   end
   if (RX_BIT >= WIDTH || TX_BIT >= WIDTH || RX_BIT == TX_BIT) begin : g_bad_bits
      $error("gpio_port: override bits invalid");
   end

   gpio_sel_e        sel;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel = decode_sel(int'(bus_addr), PIN_OFS, DIR_OFS, DATA_OFS);

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_sel & bus_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_pad_ctrl #(
      .WIDTH  (WIDTH),
      .USE_RX (USE_RX),
      .USE_TX (USE_TX),
      .RX_BIT (RX_BIT),
      .TX_BIT (TX_BIT)
   ) u_pad (
      .rst_n   (rst_n),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .rx_en   (rx_en),
      .tx_en   (tx_en),
      .tx_data (tx_data),
      .pin_oe  (pin_oe),
      .pin_out (pin_out),
      .pin_pu  (pin_pu)
   );

   always_comb begin
      unique case (sel)
         SEL_DATA: bus_rdata = latch_q;
         SEL_DIR:  bus_rdata = dir_q;
         SEL_PIN:  bus_rdata = pin_sync;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 3,
   parameter int PIN_OFS     = 1,
   parameter int DIR_OFS     = 2,
   parameter int DATA_OFS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_RX      = 1'b1,
   parameter bit USE_TX      = 1'b1,
   parameter int RX_BIT      = 0,
   parameter int TX_BIT      = 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic              rx_en,
   input logic              tx_en,
   input logic              tx_data,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_pu,
   input logic [WIDTH-1:0]  latch_q,
   input logic [WIDTH-1:0]  dir_q,
   input logic [WIDTH-1:0]  pin_sync
);
   logic wr_data, wr_pin;
   assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_W'(DATA_OFS));
   assign wr_pin  = bus_sel && bus_wr && (bus_addr == ADDR_W'(PIN_OFS));

   // R2: data write lands one clock later
   assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> latch_q == $past(bus_wdata));

   // R8: pin-level offset is read-only
   assert_pin_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pin |=> ($stable(latch_q) && $stable(dir_q)));

   // R9: reset tri-states every pin without a clock edge
   always_comb begin
      if (!rst_n) assert_reset_tristate_R9: assert (pin_oe == '0);
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic ovr;
      if (USE_RX && i == RX_BIT)      begin : g_r assign ovr = rx_en; end
      else if (USE_TX && i == TX_BIT) begin : g_t assign ovr = tx_en; end
      else                            begin : g_n assign ovr = 1'b0;  end

      // R3
      assert_output_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!ovr && dir_q[i]) |-> (pin_oe[i] && (pin_out[i] == latch_q[i]) && !pin_pu[i]));
      // R4
      assert_input_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!ovr && !dir_q[i]) |-> (!pin_oe[i] && (pin_pu[i] == latch_q[i])));
   end

   if (USE_RX) begin : g_rx_chk
      // R6
      assert_rx_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rx_en |-> (!pin_oe[RX_BIT] && (pin_pu[RX_BIT] == latch_q[RX_BIT])));
   end
   if (USE_TX) begin : g_tx_chk
      // R7
      assert_tx_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
         tx_en |-> (pin_oe[TX_BIT] && (pin_out[TX_BIT] == tx_data) && !pin_pu[TX_BIT]));
   end

   if (SYNC_STAGES == 2) begin : g_sync_chk
      logic [1:0] since_rst;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               since_rst <= '0;
         else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
      // R5
      assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));
   end else begin : g_no_sync_chk
      logic unused_s;
      assign unused_s = ^{pin_in, pin_sync};
   end
endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .PIN_OFS(PIN_OFS), .DIR_OFS(DIR_OFS),
   .DATA_OFS(DATA_OFS), .SYNC_STAGES(SYNC_STAGES), .USE_RX(USE_RX),
   .USE_TX(USE_TX), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_en(rx_en), .tx_en(tx_en),
   .tx_data(tx_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
   .pin_pu(pin_pu), .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
   localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PU = 3;
   localparam logic [2:0] A_PIN = 3'd1, A_DIR = 3'd2, A_DATA = 3'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_en = 1'b0, tx_en = 1'b0, tx_data = 1'b0;
   logic [7:0] pin_in, pin_oe, pin_out, pin_pu;
   logic [7:0] ext_en = '0, ext_val = '0;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // resolved pad model: own driver wins, then external driver, then weak pull-up, else low
   always_comb begin
      for (int i = 0; i < 8; i++) begin
         if (pin_oe[i])      pin_in[i] = pin_out[i];
         else if (ext_en[i]) pin_in[i] = ext_val[i];
         else if (pin_pu[i]) pin_in[i] = 1'b1;
         else                pin_in[i] = 1'b0;
      end
   end

   gpio_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_en(rx_en), .tx_en(tx_en), .tx_data(tx_data), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
   );

   typedef struct {
      int         due;
      int         kind;
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb[$];

   function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endfunction

   function automatic logic [7:0] observe(int kind);
      case (kind)
         K_RD:    return bus_rdata;
         K_OE:    return pin_oe;
         K_OUT:   return pin_out;
         default: return pin_pu;
      endcase
   endfunction

   function automatic void push(int delay, int kind, logic [7:0] exp, string tag);
      exp_t e;
      e.due = cyc + delay; e.kind = kind; e.exp = exp; e.tag = tag;
      sb.push_back(e);
   endfunction

   // monitor: compares each item at the falling edge of its due cycle
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            check(sb[i].tag, observe(sb[i].kind), sb[i].exp);
            sb.delete(i);
         end
      end
   end

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic expect_read(logic [2:0] a, logic [7:0] exp, string tag);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      push(0, K_RD, exp, tag);
      settle();
      bus_sel = 1'b0;
   endtask

   task automatic expect_pads(logic [7:0] oe, logic [7:0] out, logic [7:0] pu, string tag);
      @(posedge clk); #1;
      push(0, K_OE, oe, {tag, " oe"});
      push(0, K_OUT, out, {tag, " out"});
      push(0, K_PU, pu, {tag, " pu"});
      settle();
   endtask

   initial begin
      // R1 / R9: held in reset, pads tri-stated
      repeat (3) @(posedge clk);
      #1;
      check("R9 oe during reset", pin_oe, 8'h00);
      check("R1 pu during reset", pin_pu, 8'h00);
      rst_n = 1'b1;
      expect_read(A_DATA, 8'h00, "R1 latch after reset");
      expect_read(A_DIR,  8'h00, "R1 dir after reset");
      expect_pads(8'h00, 8'h00, 8'h00, "R1 pads after reset");

      // R2 / R3 / R4: first pattern
      bus_write(A_DATA, 8'h3C);
      bus_write(A_DIR,  8'h0F);
      expect_read(A_DATA, 8'h3C, "R2 latch readback");
      expect_read(A_DIR,  8'h0F, "R2 dir readback");
      expect_pads(8'h0F, 8'h3C, 8'h30, "R3 R4 pattern 3C/0F");

      // second pattern
      bus_write(A_DATA, 8'hA5);
      bus_write(A_DIR,  8'hF0);
      expect_pads(8'hF0, 8'hA5, 8'h05, "R3 R4 pattern A5/F0");

      // R10: unmapped offsets
      expect_read(3'd0, 8'h00, "R10 offset 0");
      expect_read(3'd4, 8'h00, "R10 offset 4");
      expect_read(3'd7, 8'h00, "R10 offset 7");

      // R5: two-cycle pin latency, latch read unaffected
      bus_write(A_DATA, 8'h00);
      bus_write(A_DIR,  8'h00);
      ext_en = 8'hFF; ext_val = 8'h00;
      repeat (3) @(posedge clk);
      @(posedge clk); #1;
      ext_val = 8'hA5;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_PIN;
      push(0, K_RD, 8'h00, "R5 pin read same cycle");
      push(1, K_RD, 8'h00, "R5 pin read one cycle");
      push(2, K_RD, 8'hA5, "R5 pin read two cycles");
      repeat (3) settle();
      bus_sel = 1'b0;
      expect_read(A_DATA, 8'h00, "R5 latch not pins");
      ext_en = 8'h00;

      // R8: write to pin offset ignored
      bus_write(A_DATA, 8'h81);
      bus_write(A_DIR,  8'h42);
      bus_write(A_PIN,  8'h5A);
      expect_read(A_DATA, 8'h81, "R8 latch unchanged");
      expect_read(A_DIR,  8'h42, "R8 dir unchanged");

      // R6: receive override on bit 0
      bus_write(A_DATA, 8'h01);
      bus_write(A_DIR,  8'h01);
      expect_pads(8'h01, 8'h01, 8'h00, "R6 before override");
      rx_en = 1'b1;
      expect_pads(8'h00, 8'h01, 8'h01, "R6 override latch 1");
      bus_write(A_DATA, 8'h00);
      expect_pads(8'h00, 8'h00, 8'h00, "R6 override latch 0");
      rx_en = 1'b0;

      // R7: transmit override on bit 1
      bus_write(A_DATA, 8'h00);
      bus_write(A_DIR,  8'h00);
      tx_en = 1'b1; tx_data = 1'b1;
      expect_pads(8'h02, 8'h02, 8'h00, "R7 tx high");
      tx_data = 1'b0;
      expect_pads(8'h02, 8'h00, 8'h00, "R7 tx low");
      expect_read(A_DIR,  8'h00, "R7 dir kept");
      expect_read(A_DATA, 8'h00, "R7 latch kept");
      tx_en = 1'b0;
      expect_pads(8'h00, 8'h00, 8'h00, "R7 override released");

      // R9: asynchronous reset mid-cycle with transmit override active
      bus_write(A_DATA, 8'hFF);
      bus_write(A_DIR,  8'hFF);
      tx_en = 1'b1;
      @(posedge clk); #0.5;
      rst_n = 1'b0;
      #0.5;
      check("R9 oe async", pin_oe, 8'h00);
      check("R9 pu async", pin_pu, 8'h00);
      tx_en = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      expect_read(A_DATA, 8'h00, "R1 latch after second reset");
      expect_read(A_DIR,  8'h00, "R1 dir after second reset");

      repeat (3) @(posedge clk);
      if (sb.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule